// File: doc/BRIEF.md
# Address-Range Cache Clean Sequencer

This block walks a contiguous byte range through a set-associative cache's tag store one line at a time. It cleans or invalidates every cached line that falls inside the range, and it runs while the processor carries on with other work. A single command supplies a base address, a byte length and an operation. The sequencer rounds the base down to a line boundary and issues one tag lookup per cycle. It checks every way of the indexed set in parallel and then acts on the way that matches.

A dirty hit raises a writeback request to the data path and holds the pipeline until the request is accepted. After that, the tag entry is updated: a clean clears only the dirty bit, and an invalidate clears the valid bit. A clean hit under invalidate is dropped without bus traffic. A miss does nothing. An operation marked as a hint never waits for the writeback path: a dirty line whose writeback cannot be accepted at once is skipped.

A translation fault reported against a lookup address stops the walk before that line. The block then reports how many bytes, counted from the base, are finished, so software can restart at base plus that count. Status is a busy level, a one-cycle done pulse, a sticky fault flag and the completed-byte count.

Top module: `cache_range_sweeper`

## Requirements
- R1: Lines are LINE_BYTES (64) bytes. The first lookup address is the base with its low 6 bits cleared, each later lookup address is 64 higher, and a command covers ceil((base mod 64 + length) / 64) lines.
- R2: With the writeback path always ready, the lookups are issued on consecutive cycles with no gap. For N lines, done pulses in the cycle after the (N+1)th rising edge that follows the edge sampling the start. A length of zero gives done after one edge.
- R3: Tag entries whose line address lies outside the covered lines are never modified and never written back.
- R4: A dirty hit in a non-hint operation raises wb_req with a stable address and way until wb_ready accepts it, once per line. Clean hits and misses raise no request.
- R5: The operation encoding uses two bits. cmd_op bit 0 set selects invalidate, which clears the valid bit of every hit after any writeback. Bit 0 clear selects clean, which clears only the dirty bit of dirty hits and leaves clean hits unchanged.
- R6: busy is high from the edge after an accepted start until the done edge. done is a one-cycle pulse with busy low. After a normal finish, bytes_done equals the length.
- R7: If xlat_fault is high in a cycle where a lookup would be issued, that line and all later lines are left untouched, and fault is set and stays high until the next start. done pulses two edges after the stop when no writeback is pending. bytes_done is k*64 - (base mod 64) capped at the length, or 0 when k = 0, where k is the number of lines finished. Restarting at base + bytes_done with the remaining length finishes the job.
- R8: cmd_op bit 1 set marks a hint. A hint never stalls. A dirty hit whose writeback is not ready in that cycle is skipped, with no tag change. The cycle count of R2 holds whatever wb_ready does.
- R9: cmd_start while busy is ignored, and the running command finishes with its own range and operation.
- R10: Each tag update and writeback names exactly one way, as a one-hot vector, and that way is the one whose stored tag matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Start pulse for a new range command |
| cmd_base | input | ADDR_W | Byte address where the range begins |
| cmd_len | input | ADDR_W | Range length in bytes |
| cmd_op | input | 2 | Bit 0 invalidate, bit 1 hint |
| lkup_en | output | 1 | Tag lookup strobe; data returns one cycle later |
| lkup_addr | output | ADDR_W | Line-aligned address being looked up |
| lkup_set | output | IDX_W | Set index of the lookup |
| rd_valid | input | WAYS | Valid bits of the set read in the previous cycle |
| rd_dirty | input | WAYS | Dirty bits of the set read in the previous cycle |
| rd_tag | input | WAYS*TAG_W | Stored tags of the set, way 0 in the low bits |
| upd_en | output | 1 | Tag update strobe |
| upd_set | output | IDX_W | Set to update |
| upd_way | output | WAYS | One-hot way to update |
| upd_clr_valid | output | 1 | Clear the valid bit |
| upd_clr_dirty | output | 1 | Clear the dirty bit |
| wb_req | output | 1 | Writeback request for a dirty line |
| wb_addr | output | ADDR_W | Line address to write back |
| wb_way | output | WAYS | One-hot way holding the line |
| wb_ready | input | 1 | Writeback request accepted this cycle |
| xlat_fault | input | 1 | The current lookup address faults |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last command stopped on a fault |
| bytes_done | output | ADDR_W | Bytes finished, counted from the base |

## Verification
The tag-store model in the bench answers a lookup one cycle after lkup_en and applies updates at the edge where upd_en is high. The expected state of every tag entry is therefore computed arithmetically from the range before each command and compared only after done. Done is due N+1 edges after the start edge, or k+2 edges after the start for a fault met at line k. The bench counts rising edges from the start edge and samples one time unit after each edge, so the count it reports is the edge at which done became visible. bytes_done, fault and the writeback count are read in that same sampled cycle. Commands with a writeback path that is never ready or that toggles are checked for final state only, except hints, whose edge count does not depend on readiness.

// File: rtl/crs_pkg.sv
// Shared types for the range sweeper.
// Assumes: nothing beyond the encoding of the two command bits.
package crs_pkg;
    typedef struct packed {
        logic hint;   // bit 1: may be skipped in part
        logic inval;  // bit 0: clear valid instead of only dirty
    } crs_op_t;
endpackage

// File: rtl/crs_line_count.sv
// Number of cache lines touched by a byte range.
// Assumes: the sum of length, offset and line size minus one fits ADDR_W+1 bits.
module crs_line_count #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    parameter int CNT_W  = ADDR_W - OFF_W + 1
) (
    input  logic [OFF_W-1:0]  base_off,
    input  logic [ADDR_W-1:0] len,
    output logic [CNT_W-1:0]  nlines
);
    localparam int SUM_W = ADDR_W + 1;

    logic [SUM_W-1:0] sum;

    // Round the end of the range up to a line boundary.
    always_comb begin
        sum    = {1'b0, len} + SUM_W'(base_off) + SUM_W'((1 << OFF_W) - 1);
        nlines = sum[SUM_W-1:OFF_W];
    end
endmodule

// File: rtl/crs_progress.sv
// Bytes completed, measured from the unrounded base, capped at the length.
// Assumes: lines_done never exceeds the line count of the same command.
module crs_progress #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    parameter int CNT_W  = ADDR_W - OFF_W + 1
) (
    input  logic [OFF_W-1:0]  base_off,
    input  logic [ADDR_W-1:0] len,
    input  logic [CNT_W-1:0]  lines_done,
    output logic [ADDR_W-1:0] bytes
);
    localparam int SPAN_W = CNT_W + OFF_W;

    logic [SPAN_W-1:0] span;

    // Span of finished lines minus the part of the first line before the base.
    always_comb begin
        span = {lines_done, {OFF_W{1'b0}}} - SPAN_W'(base_off);
        if (lines_done == '0)
            bytes = '0;
        else if (span >= SPAN_W'(len))
            bytes = len;
        else
            bytes = span[ADDR_W-1:0];
    end
endmodule

// File: rtl/crs_way_match.sv
// Parallel tag compare across all ways of one set.
// Assumes: at most one valid way holds a given tag.
module crs_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 20
) (
    input  logic [TAG_W-1:0]      want,
    input  logic [WAYS*TAG_W-1:0] tags,
    input  logic [WAYS-1:0]       valid,
    input  logic [WAYS-1:0]       dirty,
    output logic                  hit,
    output logic [WAYS-1:0]       way,
    output logic                  hit_dirty
);
    // One comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way[w] = valid[w] && (tags[w*TAG_W +: TAG_W] == want);
    end

    // Reduce the per-way results.
    always_comb begin
        hit       = |way;
        hit_dirty = |(way & dirty);
    end
endmodule

// File: rtl/crs_issue.sv
// Lookup address generator: holds the next line address and the count of
// lines still to be looked up; steps once per issued lookup.
// Assumes: step is only raised while left_nz is high.
module crs_issue #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    parameter int CNT_W  = ADDR_W - OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CNT_W-1:0]  load_count,
    input  logic              step,
    input  logic              kill,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              left_nz
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(1) << OFF_W;

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;

    // Load, cancel or advance the line pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            left_q <= load_count;
        end else if (kill) begin
            left_q <= '0;
        end else if (step) begin
            addr_q <= addr_q + STRIDE;
            left_q <= left_q - 1'b1;
        end
    end

    assign cur_addr = addr_q;
    assign left_nz  = (left_q != '0);

    // R1: the pointer never steps past the last covered line.
    a_r1_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> left_q != '0);
endmodule

// File: rtl/cache_range_sweeper.sv
// Range sweeper top: accepts a command, issues one tag lookup per cycle,
// resolves each returned set in the next cycle, writes back dirty hits,
// updates tags and reports progress.
// Assumes: tag data returns exactly one cycle after lkup_en; SETS >= 2 so
// an update never races a lookup of the same set in the next cycle.
module cache_range_sweeper #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int SETS       = 64,
    parameter int WAYS       = 4,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(SETS),
    localparam int TAG_W     = ADDR_W - OFF_W - IDX_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_start,
    input  logic [ADDR_W-1:0]     cmd_base,
    input  logic [ADDR_W-1:0]     cmd_len,
    input  logic [1:0]            cmd_op,
    output logic                  lkup_en,
    output logic [ADDR_W-1:0]     lkup_addr,
    output logic [IDX_W-1:0]      lkup_set,
    input  logic [WAYS-1:0]       rd_valid,
    input  logic [WAYS-1:0]       rd_dirty,
    input  logic [WAYS*TAG_W-1:0] rd_tag,
    output logic                  upd_en,
    output logic [IDX_W-1:0]      upd_set,
    output logic [WAYS-1:0]       upd_way,
    output logic                  upd_clr_valid,
    output logic                  upd_clr_dirty,
    output logic                  wb_req,
    output logic [ADDR_W-1:0]     wb_addr,
    output logic [WAYS-1:0]       wb_way,
    input  logic                  wb_ready,
    input  logic                  xlat_fault,
    output logic                  busy,
    output logic                  done,
    output logic                  fault,
    output logic [ADDR_W-1:0]     bytes_done
);
    import crs_pkg::*;

    localparam int CNT_W = ADDR_W - OFF_W + 1;

    // Command and status state.
    logic              busy_q, done_q, fault_q;
    crs_op_t           op_q;
    logic [ADDR_W-1:0] base_q, len_q;
    logic [CNT_W-1:0]  lines_done_q;

    // Resolve stage state.
    logic              s1_valid_q;
    logic [ADDR_W-1:0] s1_addr_q;
    logic              held_q;
    logic [WAYS-1:0]   held_way_q;

    // Combinational control.
    logic              start_acc, can_issue, fault_stop, left_nz, finish;
    logic [CNT_W-1:0]  cmd_lines;
    logic [ADDR_W-1:0] cur_addr;
    logic              m_hit, m_dirty;
    logic [WAYS-1:0]   m_way;
    logic              eff_hit, eff_dirty;
    logic [WAYS-1:0]   eff_way;
    logic              dirty_hit, wb_fire, stall, s1_adv;

    assign start_acc = cmd_start && !busy_q;

    crs_line_count #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) i_count (
        .base_off (cmd_base[OFF_W-1:0]),
        .len      (cmd_len),
        .nlines   (cmd_lines)
    );

    crs_issue #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) i_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start_acc),
        .load_addr  ({cmd_base[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}),
        .load_count (cmd_lines),
        .step       (lkup_en),
        .kill       (fault_stop),
        .cur_addr   (cur_addr),
        .left_nz    (left_nz)
    );

    crs_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_match (
        .want      (s1_addr_q[ADDR_W-1 -: TAG_W]),
        .tags      (rd_tag),
        .valid     (rd_valid),
        .dirty     (rd_dirty),
        .hit       (m_hit),
        .way       (m_way),
        .hit_dirty (m_dirty)
    );

    crs_progress #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) i_progress (
        .base_off   (base_q[OFF_W-1:0]),
        .len        (len_q),
        .lines_done (lines_done_q),
        .bytes      (bytes_done)
    );

    // Resolve stage: use the live compare, or the way captured while stalled.
    always_comb begin
        eff_hit   = held_q || m_hit;
        eff_way   = held_q ? held_way_q : m_way;
        eff_dirty = held_q || m_dirty;
        dirty_hit = s1_valid_q && eff_hit && eff_dirty;
        wb_fire   = dirty_hit && wb_ready;
        stall     = dirty_hit && !wb_ready && !op_q.hint;
        s1_adv    = s1_valid_q && !stall;
    end

    // Issue stage: one lookup per cycle unless stalled or faulted.
    always_comb begin
        can_issue  = busy_q && left_nz && !stall;
        lkup_en    = can_issue && !xlat_fault;
        fault_stop = can_issue && xlat_fault;
        finish     = busy_q && !left_nz && (!s1_valid_q || s1_adv);
    end

    assign lkup_addr = cur_addr;
    assign lkup_set  = cur_addr[OFF_W +: IDX_W];

    // Tag update and writeback outputs of the resolve stage.
    always_comb begin
        upd_en        = s1_valid_q && eff_hit && (eff_dirty ? wb_fire : op_q.inval);
        upd_set       = s1_addr_q[OFF_W +: IDX_W];
        upd_way       = eff_way;
        upd_clr_valid = op_q.inval;
        upd_clr_dirty = eff_dirty;
        wb_req        = dirty_hit;
        wb_addr       = s1_addr_q;
        wb_way        = eff_way;
    end

    // Command capture, progress count and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q       <= 1'b0;
            done_q       <= 1'b0;
            fault_q      <= 1'b0;
            op_q         <= '0;
            base_q       <= '0;
            len_q        <= '0;
            lines_done_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (start_acc) begin
                busy_q       <= 1'b1;
                fault_q      <= 1'b0;
                op_q         <= crs_op_t'(cmd_op);
                base_q       <= cmd_base;
                len_q        <= cmd_len;
                lines_done_q <= '0;
            end else if (busy_q) begin
                if (fault_stop) fault_q <= 1'b1;
                if (s1_adv) lines_done_q <= lines_done_q + 1'b1;
                if (finish) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    // Resolve stage registers: advance with each lookup, hold while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid_q <= 1'b0;
            s1_addr_q  <= '0;
            held_q     <= 1'b0;
            held_way_q <= '0;
        end else begin
            s1_valid_q <= stall || lkup_en;
            if (lkup_en) s1_addr_q <= cur_addr;
            if (s1_adv) begin
                held_q <= 1'b0;
            end else if (stall && !held_q) begin
                held_q     <= 1'b1;
                held_way_q <= m_way;
            end
        end
    end

    assign busy  = busy_q;
    assign done  = done_q;
    assign fault = fault_q;

    // R2: lookups only happen inside a command.
    a_r2_lookup_busy: assert property (@(posedge clk) disable iff (!rst_n)
        lkup_en |-> busy);

    // R1: back-to-back lookups move forward by exactly one line.
    a_r1_line_step: assert property (@(posedge clk) disable iff (!rst_n)
        (lkup_en && $past(lkup_en)) |-> lkup_addr == $past(lkup_addr) + ADDR_W'(LINE_BYTES));

    // R4: a refused request of a normal command is held unchanged.
    a_r4_wb_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ready && !op_q.hint) |=> (wb_req && $stable(wb_addr) && $stable(wb_way)));

    // R6: done is a single-cycle pulse and never overlaps busy.
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: a start while busy leaves the captured command untouched.
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_start) |=> ($stable(base_q) && $stable(len_q) && $stable(op_q)));

    // R10: updates and writebacks name exactly one way.
    a_r10_upd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> $onehot(upd_way));
    a_r10_wb_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> $onehot(wb_way));
endmodule

// File: tb/test_cache_range_sweeper.sv
// Sweep bench: small cache (8 sets, 2 ways, 16-bit addresses), a tag-store
// model with one-cycle read latency, expected state computed per command.
module test_cache_range_sweeper;
    localparam int AW = 16;
    localparam int NS = 8;
    localparam int NW = 2;
    localparam int IW = 3;
    localparam int TW = AW - 6 - IW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 1'b0;
    logic [AW-1:0] cmd_base = '0, cmd_len = '0;
    logic [1:0] cmd_op = '0;
    logic lkup_en;
    logic [AW-1:0] lkup_addr;
    logic [IW-1:0] lkup_set;
    logic [NW-1:0] rd_valid = '0, rd_dirty = '0;
    logic [NW*TW-1:0] rd_tag = '0;
    logic upd_en, upd_clr_valid, upd_clr_dirty;
    logic [IW-1:0] upd_set;
    logic [NW-1:0] upd_way, wb_way;
    logic wb_req, wb_ready;
    logic [AW-1:0] wb_addr;
    logic xlat_fault;
    logic busy, done, fault;
    logic [AW-1:0] bytes_done;

    // Model and expectation.
    logic mv [NS][NW];
    logic md [NS][NW];
    logic [TW-1:0] mt [NS][NW];
    logic ev [NS][NW];
    logic ed [NS][NW];
    int wb_cnt = 0;
    int rdy_mode = 0;
    int rdy_ctr = 0;
    logic flt_en = 1'b0;
    logic [AW-1:0] flt_addr = '0;
    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    cache_range_sweeper #(.ADDR_W(AW), .LINE_BYTES(64), .SETS(NS), .WAYS(NW)) i_cache_range_sweeper (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_base(cmd_base),
        .cmd_len(cmd_len), .cmd_op(cmd_op), .lkup_en(lkup_en), .lkup_addr(lkup_addr),
        .lkup_set(lkup_set), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
        .upd_en(upd_en), .upd_set(upd_set), .upd_way(upd_way),
        .upd_clr_valid(upd_clr_valid), .upd_clr_dirty(upd_clr_dirty),
        .wb_req(wb_req), .wb_addr(wb_addr), .wb_way(wb_way), .wb_ready(wb_ready),
        .xlat_fault(xlat_fault), .busy(busy), .done(done), .fault(fault),
        .bytes_done(bytes_done)
    );

    assign wb_ready   = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? 1'b0 : ((rdy_ctr % 3) != 0);
    assign xlat_fault = flt_en && (lkup_addr == flt_addr);

    // Tag store: registered read, updates at the edge, writeback counter.
    always @(posedge clk) begin
        rdy_ctr <= rdy_ctr + 1;
        if (lkup_en) begin
            for (int w = 0; w < NW; w++) begin
                rd_valid[w] <= mv[lkup_set][w];
                rd_dirty[w] <= md[lkup_set][w];
                rd_tag[w*TW +: TW] <= mt[lkup_set][w];
            end
        end
        if (upd_en) begin
            for (int w = 0; w < NW; w++) begin
                if (upd_way[w]) begin
                    if (upd_clr_valid) mv[upd_set][w] <= 1'b0;
                    if (upd_clr_dirty) md[upd_set][w] <= 1'b0;
                end
            end
        end
        if (wb_req && wb_ready) wb_cnt <= wb_cnt + 1;
    end

    // Watchdog: a hung run is a failed check and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual cycle %0d expected finish before 150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Fill the cache: way w holds tag w, so lines 0..15 each live in one entry.
    task automatic init_cache();
        for (int s = 0; s < NS; s++) begin
            for (int w = 0; w < NW; w++) begin
                mt[s][w] = TW'(w);
                mv[s][w] = ((s + w) % 3) != 0;
                md[s][w] = mv[s][w] && (((s * 2 + w) % 3) == 0);
            end
        end
    endtask

    // Expected effect of a command on the current model: lim lines processed.
    function automatic int build_expect(input int base, input int lim, input int op, input bit never_rdy);
        int first = base / 64;
        int nwb = 0;
        for (int s = 0; s < NS; s++) begin
            for (int w = 0; w < NW; w++) begin
                int la = int'(mt[s][w]) * NS + s;
                bit inr = (la >= first) && (la < first + lim);
                ev[s][w] = mv[s][w];
                ed[s][w] = md[s][w];
                if (inr && mv[s][w]) begin
                    if (md[s][w]) begin
                        if (!(op[1] && never_rdy)) begin
                            nwb++;
                            ed[s][w] = 1'b0;
                            if (op[0]) ev[s][w] = 1'b0;
                        end
                    end else if (op[0]) begin
                        ev[s][w] = 1'b0;
                    end
                end
            end
        end
        return nwb;
    endfunction

    function automatic int state_mismatches();
        int n = 0;
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++)
                if (mv[s][w] !== ev[s][w] || md[s][w] !== ed[s][w]) n++;
        return n;
    endfunction

    // Pulse start, then count edges until done is seen.
    task automatic launch(input int base, input int len, input int op, output int edges);
        @(negedge clk);
        cmd_base  = AW'(base);
        cmd_len   = AW'(len);
        cmd_op    = 2'(op);
        cmd_start = 1'b1;
        @(posedge clk);
        #1 cmd_start = 1'b0;
        edges = 0;
        while (edges < 3000) begin
            @(posedge clk);
            edges++;
            #1;
            if (done) break;
        end
    endtask

    task automatic run_plain(input int base, input int len, input int op, input int mode);
        int n = ((base % 64) + len + 63) / 64;
        int wb0, nwb, edges;
        bit never = (mode == 1);
        rdy_mode = mode;
        init_cache();
        nwb = build_expect(base, n, op, never);
        wb0 = wb_cnt;
        launch(base, len, op, edges);
        check(done === 1'b1 && busy === 1'b0, "R6", "done with busy low", int'(done), 1);
        check(state_mismatches() == 0, op[0] ? "R5" : "R3", "entries differing from expected", state_mismatches(), 0);
        check(wb_cnt - wb0 == nwb, op[1] ? "R8" : "R4", "writebacks", wb_cnt - wb0, nwb);
        check(int'(bytes_done) == len, "R6", "bytes_done at finish", int'(bytes_done), len);
        if (mode == 0 || op[1])
            check(edges == n + 1, op[1] ? "R8" : "R2", "edges from start to done", edges, n + 1);
        @(posedge clk);
        #1 check(done === 1'b0, "R6", "done after pulse", int'(done), 0);
    endtask

    initial begin
        int edges, nwb, wb0, k, exp_b, resume_b;
        static int bases[5] = '{0, 5, 63, 64, 200};
        static int lens[5]  = '{0, 1, 64, 130, 700};
        init_cache();
        repeat (3) @(posedge clk);
        #1;
        check(busy === 1'b0 && done === 1'b0 && fault === 1'b0, "R6", "status in reset", int'(busy), 0);
        check(bytes_done === '0 && lkup_en === 1'b0 && wb_req === 1'b0 && upd_en === 1'b0,
              "R6", "outputs in reset", int'(bytes_done), 0);
        @(negedge clk) rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R8: sweep of bases, lengths, operations and ready patterns.
        for (int b = 0; b < 5; b++)
            for (int l = 0; l < 5; l++)
                for (int op = 0; op < 4; op++) begin
                    run_plain(bases[b], lens[l], op, op[1] ? 0 : 0);
                    run_plain(bases[b], lens[l], op, op[1] ? 1 : 2);
                end

        // R1: first lookup address is the base rounded down.
        rdy_mode = 0;
        init_cache();
        @(negedge clk);
        cmd_base = 16'd333; cmd_len = 16'd10; cmd_op = 2'd0; cmd_start = 1'b1;
        @(posedge clk);
        #1 cmd_start = 1'b0;
        check(lkup_en === 1'b1 && lkup_addr == 16'd320, "R1", "first lookup address", int'(lkup_addr), 320);
        while (busy) @(negedge clk);

        // R7: fault on the fourth line, then resume.
        for (int fl = 0; fl < 2; fl++) begin
            int base = 70;
            int len  = 500;
            k = (fl == 0) ? 3 : 0;
            rdy_mode = 0;
            init_cache();
            nwb = build_expect(base, k, 1, 0);
            flt_addr = AW'((base / 64 + k) * 64);
            flt_en = 1'b1;
            wb0 = wb_cnt;
            launch(base, len, 1, edges);
            flt_en = 1'b0;
            exp_b = (k == 0) ? 0 : ((k * 64 - base % 64) < len ? k * 64 - base % 64 : len);
            check(fault === 1'b1, "R7", "fault flag", int'(fault), 1);
            check(int'(bytes_done) == exp_b, "R7", "bytes_done at fault", int'(bytes_done), exp_b);
            check(state_mismatches() == 0, "R7", "entries after fault", state_mismatches(), 0);
            check(wb_cnt - wb0 == nwb, "R7", "writebacks before fault", wb_cnt - wb0, nwb);
            check(edges == k + 2, "R7", "edges to done on fault", edges, k + 2);
            resume_b = base + exp_b;
            nwb = build_expect(resume_b, ((resume_b % 64) + len - exp_b + 63) / 64, 1, 0);
            launch(resume_b, len - exp_b, 1, edges);
            check(fault === 1'b0, "R7", "fault cleared by new start", int'(fault), 0);
            check(state_mismatches() == 0, "R7", "entries after resume", state_mismatches(), 0);
        end

        // R9: a second start while busy is ignored.
        rdy_mode = 2;
        init_cache();
        nwb = build_expect(0, 10, 0, 0);
        @(negedge clk);
        cmd_base = 16'd0; cmd_len = 16'd640; cmd_op = 2'd0; cmd_start = 1'b1;
        @(negedge clk) cmd_start = 1'b0;
        repeat (2) @(negedge clk);
        cmd_base = 16'd128; cmd_len = 16'd900; cmd_op = 2'd1; cmd_start = 1'b1;
        @(negedge clk) cmd_start = 1'b0;
        while (!done) @(negedge clk);
        check(state_mismatches() == 0, "R9", "entries after ignored start", state_mismatches(), 0);
        check(int'(bytes_done) == 640, "R9", "bytes_done of first command", int'(bytes_done), 640);
        @(negedge clk);
        check(busy === 1'b0, "R9", "no second run", int'(busy), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule